// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol engine on the device side of a two-wire serial EEPROM with 32K byte locations. It runs from a system clock at least eight times faster than SCL. Both bus lines pass through two-flop synchronisers. From the synchronised lines the block finds start and stop conditions and SCL edges. It takes bits on SCL rising edges and changes its own open-drain SDA drive only after SCL falling edges.

A transaction opens with a select byte. The select byte carries a fixed device code, three strap bits and a direction bit. A write access then takes a two-byte memory address and any number of data bytes. Each data byte goes out on a page-buffer port, and a stop that follows data raises a commit strobe. A read access returns bytes from the internal address counter until the host refuses a byte.

One counter serves both directions. During writes it wraps inside a 64-byte page, and during reads it wraps across the whole array. While the self-timed write is busy, write selects are refused, so the host can poll for completion.

Top module: `eeprom_twi_slave`

## Requirements
- R1: After reset the SDA drive is released, no page-buffer or read strobe is active, and the address counter (visible on mem_addr) is 0.
- R2: A start condition (SDA falls while SCL is high) begins reception of a select byte from any state, including a repeated start in the middle of a transfer. A stop condition (SDA rises while SCL is high) returns the block to standby.
- R3: The select byte is taken MSB first. Bits 7:4 must equal 1010 and bits 3:1 must equal strap[2:0]. Bit 0 gives the direction, 1 for read and 0 for write. On a mismatch the block drives no ACK and stays released until the next start.
- R4: After each accepted byte the block pulls SDA low for the whole ninth SCL clock and releases it after that clock's falling edge.
- R5: A write access takes two address bytes, the high byte first. Bit 7 of the high byte is ignored, so the counter loads {high[6:0], low}.
- R6: Each write data byte appears for one cycle on pbuf_valid, with pbuf_addr equal to the counter and pbuf_data equal to the byte. After each byte the counter advances with address bits 5:0 wrapping and bits 14:6 held.
- R7: A stop that follows at least one data byte gives a single-cycle pbuf_commit. A stop after only address bytes (a dummy write) gives none.
- R8: A read sends, MSB first, the byte at the counter address, and the counter then advances by one, wrapping from 0x7FFF to 0x0000. A host ACK of 0 brings the next byte. A random read is a dummy write followed by a repeated start with a read select.
- R9: After a host NACK of 1 the block keeps SDA released and sends no data, whatever the host clocks, until a start or stop.
- R10: While wr_busy is high a write select gets no ACK. Once wr_busy is low, a write select is acknowledged.
- R11: After a write, a current-address read returns the location one past the last written byte, wrapped within its page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, unsynchronised |
| sda_in | input | 1 | Bus data line as seen on the wire, unsynchronised |
| strap | input | 3 | Hard-wired device address bits |
| wr_busy | input | 1 | High while the self-timed write cycle runs |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr | output | 15 | Address counter, used as the array read address |
| mem_rd_en | output | 1 | Strobe: the read byte at mem_addr is taken this cycle |
| mem_rdata | input | 8 | Array read data for mem_addr, at most one cycle late |
| pbuf_valid | output | 1 | Strobe: a write data byte is presented |
| pbuf_addr | output | 15 | Target address of the presented byte |
| pbuf_data | output | 8 | Presented write data byte |
| pbuf_commit | output | 1 | Strobe: stop after write data; start the write cycle |

## Verification
The hardest situations to reach are the ones that depend on the relative timing of the host's moves and the self-timed write cycle. One is a write select that lands while wr_busy is still high. The other is a host that refuses a read byte and keeps toggling SCL instead of issuing a stop. The bench models the array with a busy window that opens on pbuf_commit. It sends a poll straight after a page write's stop, so the first select meets a busy cycle and a later one does not. It then leaves a NACKed read hanging for a full byte of host clocks and watches that the line stays high. Page wrap and array wrap are reached by loading addresses at offset 62 of a page and at 0x7FFE.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } twi_state_e;

   typedef enum logic [1:0] {
      K_SEL,
      K_AHI,
      K_ALO,
      K_DAT
   } rx_kind_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_sync.sv
`timescale 1ns/1ps
module twi_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("twi_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {STAGES{RST_VAL}};
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/twi_events.sv
`timescale 1ns/1ps
module twi_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_addr_ctr.sv
`timescale 1ns/1ps
module twi_addr_ctr #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_page,
   input  logic              step_array,
   output logic [ADDR_W-1:0] cnt
);
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("twi_addr_ctr: PAGE_W must lie in 1..ADDR_W-1");
   end

   logic [ADDR_W-1:0] page_next;
   logic [ADDR_W-1:0] array_next;

   assign page_next  = {cnt[ADDR_W-1:PAGE_W], cnt[PAGE_W-1:0] + 1'b1};
   assign array_next = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (step_page)  cnt <= page_next;
      else if (step_array) cnt <= array_next;
   end
endmodule

// File: rtl/eeprom_twi_slave.sv
`timescale 1ns/1ps
module eeprom_twi_slave
   import twi_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter int PAGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [2:0]        strap,
   input  logic              wr_busy,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [7:0]        mem_rdata,
   output logic              pbuf_valid,
   output logic [ADDR_W-1:0] pbuf_addr,
   output logic [7:0]        pbuf_data,
   output logic              pbuf_commit
);
   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
      $error("eeprom_twi_slave: ADDR_W must lie in 9..16");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   twi_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   twi_state_e        state;
   rx_kind_e          kind;
   logic [3:0]        bit_cnt;
   logic [7:0]        sh;
   logic [HI_W-1:0]   hi;
   logic [6:0]        tx;
   logic              rw;
   logic              wr_pend;
   logic              host_ack;
   logic [ADDR_W-1:0] ctr;

   logic sel_ok, sel_ack, rx_done, ack_end, rd_first, rd_next, take, wr_byte, ctr_load;

   always_comb begin
      sel_ok   = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap);
      sel_ack  = sel_ok && !(!sh[0] && wr_busy);
      rx_done  = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
      ack_end  = (state == ST_ACK) && scl_fall;
      rd_first = ack_end && (kind == K_SEL) && rw;
      rd_next  = (state == ST_RACK) && scl_fall && !host_ack;
      take     = rd_first || rd_next;
      wr_byte  = rx_done && (kind == K_DAT);
      ctr_load = rx_done && (kind == K_ALO);
   end

   twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(ctr_load), .load_val({hi, sh}),
      .step_page(wr_byte), .step_array(take),
      .cnt(ctr));

   assign mem_addr    = ctr;
   assign mem_rd_en   = take;
   assign pbuf_valid  = wr_byte;
   assign pbuf_addr   = ctr;
   assign pbuf_data   = sh;
   assign pbuf_commit = stop_ev && wr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind     <= K_SEL;
         bit_cnt  <= '0;
         sh       <= '0;
         hi       <= '0;
         tx       <= '0;
         sda_oe   <= 1'b0;
         rw       <= 1'b0;
         wr_pend  <= 1'b0;
         host_ack <= 1'b1;
      end else if (start_ev) begin
         state   <= ST_RX;
         kind    <= K_SEL;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
         wr_pend <= 1'b0;
      end else if (stop_ev) begin
         state   <= ST_IDLE;
         sda_oe  <= 1'b0;
         wr_pend <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise && bit_cnt != 4'd8) begin
                  sh      <= {sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end
               if (rx_done) begin
                  case (kind)
                     K_SEL: begin
                        if (sel_ack) begin
                           state  <= ST_ACK;
                           sda_oe <= 1'b1;
                           rw     <= sh[0];
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     K_AHI: begin
                        hi     <= sh[HI_W-1:0];
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                     end
                     K_ALO: begin
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                     end
                     default: begin
                        wr_pend <= 1'b1;
                        state   <= ST_ACK;
                        sda_oe  <= 1'b1;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (kind == K_SEL && rw) begin
                     state  <= ST_TX;
                     tx     <= mem_rdata[6:0];
                     sda_oe <= ~mem_rdata[7];
                  end else begin
                     state  <= ST_RX;
                     sda_oe <= 1'b0;
                     case (kind)
                        K_SEL:   kind <= K_AHI;
                        K_AHI:   kind <= K_ALO;
                        default: kind <= K_DAT;
                     endcase
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     sda_oe  <= ~tx[6];
                     tx      <= {tx[5:0], 1'b0};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) host_ack <= sda_s;
               if (scl_fall) begin
                  if (!host_ack) begin
                     state   <= ST_TX;
                     bit_cnt <= '0;
                     tx      <= mem_rdata[6:0];
                     sda_oe  <= ~mem_rdata[7];
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/twi_slave_chk.sv
`timescale 1ns/1ps
module twi_slave_chk #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_ev,
   input logic              stop_ev,
   input logic              scl_fall,
   input logic              sda_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd_en,
   input logic              pbuf_valid,
   input logic [ADDR_W-1:0] pbuf_addr,
   input logic              pbuf_commit
);
   logic data_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   data_seen <= 1'b0;
      else if (start_ev || stop_ev) data_seen <= 1'b0;
      else if (pbuf_valid)          data_seen <= 1'b1;
   end

   // R4
   oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));

   // R7
   commit_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pbuf_commit |-> data_seen);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pbuf_valid, pbuf_commit, mem_rd_en}));

   // R8
   rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

   // R6
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pbuf_valid |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(pbuf_addr[ADDR_W-1:PAGE_W])) &&
                     (mem_addr[PAGE_W-1:0] == PAGE_W'($past(pbuf_addr[PAGE_W-1:0]) + 1'b1)));
endmodule

bind eeprom_twi_slave twi_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
   .scl_fall(scl_fall), .sda_oe(sda_oe), .mem_addr(mem_addr),
   .mem_rd_en(mem_rd_en), .pbuf_valid(pbuf_valid), .pbuf_addr(pbuf_addr),
   .pbuf_commit(pbuf_commit));

// File: tb/sim_eeprom_twi_slave.sv
`timescale 1ns/1ps
module sim_eeprom_twi_slave;
   localparam int Q        = 8;
   localparam int BUSY_CYC = 600;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};
   // {address as sent (16 bits), data}
   localparam logic [23:0] VEC [6] = '{
      24'h0010A5, 24'h81233C, 24'h7FFFE7, 24'h204001, 24'h55AA7E, 24'h3FC0C3 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_scl = 1'b1;
   logic        host_sda = 1'b1;
   logic        wr_busy;
   logic        sda_oe;
   logic [14:0] mem_addr;
   logic        mem_rd_en;
   logic [7:0]  mem_rdata = 8'h00;
   logic        pbuf_valid;
   logic [14:0] pbuf_addr;
   logic [7:0]  pbuf_data;
   logic        pbuf_commit;
   logic        sda_line;

   int checks = 0;
   int errors = 0;
   int commits = 0;
   int busy_cnt = 0;
   int wlog_n = 0;
   logic [14:0] wlog [8];
   logic [7:0]  mem  [int];
   logic [7:0]  pend [int];
   logic [7:0]  refm [int];

   always #2.5 clk = ~clk;

   assign sda_line = host_sda & ~sda_oe;
   assign wr_busy  = (busy_cnt != 0);

   eeprom_twi_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_line),
      .strap(STRAP), .wr_busy(wr_busy), .sda_oe(sda_oe),
      .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
      .pbuf_valid(pbuf_valid), .pbuf_addr(pbuf_addr), .pbuf_data(pbuf_data),
      .pbuf_commit(pbuf_commit));

   function automatic logic [7:0] pat(int a);
      return 8'(a ^ (a >> 7)) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_at(int a);
      return refm.exists(a) ? refm[a] : pat(a);
   endfunction

   // array model: one-cycle read, page buffer applied on commit, busy window
   always @(negedge clk) begin
      mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : pat(int'(mem_addr));
      if (pbuf_valid) begin
         pend[int'(pbuf_addr)] = pbuf_data;
         if (wlog_n < 8) wlog[wlog_n] = pbuf_addr;
         wlog_n++;
      end
      if (pbuf_commit) begin
         foreach (pend[k]) mem[k] = pend[k];
         pend.delete();
         commits++;
         busy_cnt = BUSY_CYC;
      end else if (busy_cnt > 0) begin
         busy_cnt--;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      host_sda = b; tick(Q); host_scl = 1'b1; tick(2*Q); host_scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q); b = sda_line; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic do_start();
      host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q); host_sda = 1'b0; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic do_stop();
      host_sda = 1'b0; tick(Q); host_scl = 1'b1; tick(Q); host_sda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(ack);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic hack);
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      put_bit(hack);
   endtask

   task automatic set_addr(input logic [15:0] a, output logic [2:0] acks);
      do_start();
      send_byte(SEL_W, acks[2]);
      send_byte(a[15:8], acks[1]);
      send_byte(a[7:0], acks[0]);
   endtask

   task automatic wait_ready();
      while (wr_busy) tick(1);
      tick(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0]  acks;
      logic        a0, a1;
      logic [7:0]  v, v1, v2;
      int          c0;

      tick(10);
      rst_n = 1'b1;
      tick(4);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1 sda released", 32'(sda_oe), 0);
      chk(mem_addr == 15'd0 && !pbuf_valid && !mem_rd_en, "R1 counter zero, strobes idle",
          32'(mem_addr), 0);

      // R1/R8: current-address read from reset returns location 0
      do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
      chk(a0 == 1'b0 && v == exp_at(0), "R8 current read after reset", 32'(v), 32'(exp_at(0)));

      // vector table: byte write then random read
      for (int i = 0; i < 6; i++) begin
         logic [15:0] a16;
         logic [7:0]  d;
         logic        ad;
         a16 = VEC[i][23:8];
         d   = VEC[i][7:0];
         wlog_n = 0;
         c0 = commits;
         set_addr(a16, acks);
         send_byte(d, ad);
         do_stop();
         tick(4);
         chk(acks == 3'b000 && ad == 1'b0, "R4 write access acks", 32'({acks, ad}), 0);
         chk(wlog_n == 1 && wlog[0] == a16[14:0], "R5 page port address, top bit ignored",
             32'(wlog[0]), 32'(a16[14:0]));
         chk(commits == c0 + 1, "R7 commit after data stop", 32'(commits), 32'(c0 + 1));
         refm[int'(a16[14:0])] = d;
         wait_ready();
         c0 = commits;
         set_addr(a16, acks);
         do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
         tick(4);
         chk(v == d && a0 == 1'b0, "R8 random read data", 32'(v), 32'(d));
         chk(commits == c0, "R7 dummy write gives no commit", 32'(commits), 32'(c0));
      end

      // R3: wrong device code, then standby for the following byte
      do_start(); send_byte({4'b1011, STRAP, 1'b0}, a0); send_byte(8'h00, a1); do_stop();
      chk(a0 == 1'b1, "R3 wrong code not acked", 32'(a0), 1);
      chk(a1 == 1'b1, "R3 standby after mismatch", 32'(a1), 1);
      // R3: wrong strap
      do_start(); send_byte({4'b1010, 3'b100, 1'b1}, a0); do_stop();
      chk(a0 == 1'b1, "R3 wrong strap not acked", 32'(a0), 1);

      // R6: page write starting at offset 62 wraps to the page start
      wlog_n = 0;
      set_addr(16'h0ABE, acks);
      send_byte(8'h11, a0); send_byte(8'h22, a0); send_byte(8'h33, a1);
      do_stop();
      tick(4);
      chk(wlog_n == 3, "R6 three bytes presented", 32'(wlog_n), 3);
      chk(wlog[0] == 15'h0ABE && wlog[1] == 15'h0ABF, "R6 in-page increment",
          32'({wlog[0], wlog[1]}), 32'({15'h0ABE, 15'h0ABF}));
      chk(wlog[2] == 15'h0A80, "R6 page wrap", 32'(wlog[2]), 32'h0A80);
      refm[32'h0ABE] = 8'h11; refm[32'h0ABF] = 8'h22; refm[32'h0A80] = 8'h33;

      // R10: poll while busy, then after
      do_start(); send_byte(SEL_W, a0); do_stop();
      chk(a0 == 1'b1, "R10 write select refused while busy", 32'(a0), 1);
      wait_ready();
      do_start(); send_byte(SEL_W, a0); do_stop();
      chk(a0 == 1'b0, "R10 write select acked when idle", 32'(a0), 0);

      // R11: current-address read after the page write
      do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
      chk(v == exp_at(32'h0A81), "R11 counter after write wraps in page", 32'(v),
          32'(exp_at(32'h0A81)));
      set_addr(16'h0A80, acks); do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
      chk(v == 8'h33, "R6 wrapped byte stored at page start", 32'(v), 32'h33);

      // R8/R2: sequential read across the top of the array, repeated start
      set_addr(16'h7FFE, acks);
      do_start(); send_byte(SEL_R, a0);
      recv_byte(v, 1'b0); recv_byte(v1, 1'b0); recv_byte(v2, 1'b1); do_stop();
      chk(v == exp_at(32'h7FFE) && v1 == exp_at(32'h7FFF), "R8 sequential bytes",
          32'({v, v1}), 32'({exp_at(32'h7FFE), exp_at(32'h7FFF)}));
      chk(v2 == exp_at(0), "R8 array wrap to zero", 32'(v2), 32'(exp_at(0)));
      do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
      chk(v == exp_at(1), "R8 current read follows sequence", 32'(v), 32'(exp_at(1)));

      // R9: NACK without stop, host keeps clocking
      set_addr(16'h0010, acks); do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1);
      begin
         logic [8:0] seen;
         for (int i = 0; i < 9; i++) get_bit(seen[i]);
         chk(seen == 9'h1FF, "R9 bus stays released after NACK", 32'(seen), 32'h1FF);
      end
      do_stop();
      chk(v == 8'hA5, "R8 random read before hang", 32'(v), 32'hA5);

      // R2: a new start works after the hang
      do_start(); send_byte(SEL_R, a0); recv_byte(v, 1'b1); do_stop();
      chk(a0 == 1'b0 && v == exp_at(32'h11), "R2 recovery by start", 32'(v), 32'(exp_at(32'h11)));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule